// File: doc/BRIEF.md
# Stack Pointer Sequencer for an 8-bit Core

This block keeps the stack pointer of a small 8-bit processor and turns the core's stack commands into byte accesses on a data-memory port. The stack grows downward. A byte push stores at the current pointer and then steps the pointer down. A byte pop steps the pointer up and then reads. A call or interrupt stores a 24-bit return address as three bytes over three cycles. A return reads those three bytes back over three cycles and presents the rebuilt address. Software sees the pointer as two byte registers, low and high. On small memory configurations the high register can be removed by a parameter.

The sequencer is a state machine. In `ST_IDLE` it accepts one strobe per cycle. A byte push completes in `ST_IDLE`. A byte pop goes `ST_IDLE -> ST_POP_WAIT -> ST_IDLE`. A call goes `ST_IDLE -> ST_CALL_MID -> ST_CALL_LOW -> ST_IDLE`. A return goes `ST_IDLE -> ST_RET_MID -> ST_RET_HIGH -> ST_RET_DONE -> ST_IDLE`. Every state other than `ST_IDLE` raises `busy`.

Each software write also re-evaluates a floor flag. The flag reports a pointer placed below the lowest address the stack may use.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals parameter `SRAM_LAST` (default 0x02FF), `floor_err` is 0, `busy` is 0 and no memory strobe is active.
- R2: A byte push accepted in `ST_IDLE` drives `mem_we` with `mem_addr` equal to the current pointer and `mem_wdata` equal to `push_data` in the same cycle. The pointer is one lower on the next cycle.
- R3: A call writes the return address on three consecutive cycles. Bits 23:16 go to the pointer P, bits 15:8 to P-1 and bits 7:0 to P-2. `busy` is high on the second and third cycles, and the pointer ends at P-3.
- R4: A byte pop raises `mem_re` at the pointer plus one and moves the pointer up by one. On the next cycle `pop_valid` is high and `pop_data` holds the byte read, given that memory returns read data one cycle after `mem_re`.
- R5: A return reads P+1, P+2 and P+3 on three consecutive cycles as bits 7:0, 15:8 and 23:16. On the fourth cycle `ret_valid` is high and `ret_addr_out` holds the 24-bit address, and the pointer ends at P+3.
- R6: `rd_lo` and `rd_hi` always show pointer bits 7:0 and 15:8. A write strobe `sw_wr_lo` or `sw_wr_hi` replaces that byte with `sw_wdata` from the next cycle on.
- R7: After every software write, `floor_err` is 1 exactly when the new pointer is below parameter `FLOOR` (default 0x0200). Pushes, pops, calls and returns leave `floor_err` unchanged.
- R8: With `HAS_HIGH` = 0 the pointer is 8 bits wide. `rd_hi` reads 0, `sw_wr_hi` has no effect, and pointer arithmetic wraps within 8 bits.
- R9: When a software write and a stack command arrive in the same `ST_IDLE` cycle, the pointer takes the written value. The command is dropped, and neither `mem_we` nor `mem_re` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_lo | input | 1 | Software write strobe, pointer low byte |
| sw_wr_hi | input | 1 | Software write strobe, pointer high byte |
| sw_wdata | input | 8 | Software write data |
| rd_lo | output | 8 | Pointer bits 7:0 |
| rd_hi | output | 8 | Pointer bits 15:8 (0 when `HAS_HIGH` = 0) |
| floor_err | output | 1 | Last software write put the pointer below `FLOOR` |
| cmd_push | input | 1 | Byte push strobe |
| cmd_pop | input | 1 | Byte pop strobe |
| cmd_call | input | 1 | Return-address push strobe |
| cmd_ret | input | 1 | Return-address pop strobe |
| push_data | input | 8 | Byte to push |
| ret_addr_in | input | 24 | Return address to push |
| busy | output | 1 | Multi-cycle sequence in progress |
| pop_valid | output | 1 | `pop_data` valid this cycle |
| pop_data | output | 8 | Popped byte |
| ret_valid | output | 1 | `ret_addr_out` valid this cycle |
| ret_addr_out | output | 24 | Rebuilt return address |
| mem_addr | output | 16 | Data-memory byte address |
| mem_we | output | 1 | Data-memory write strobe |
| mem_re | output | 1 | Data-memory read strobe |
| mem_wdata | output | 8 | Data-memory write data |
| mem_rdata | input | 8 | Data-memory read data, one cycle after `mem_re` |

## Verification
The properties assume that at most one command strobe is high in any cycle. They also assume that no command or software write arrives while `busy` is high, so every three-cycle pointer window sees only the sequencer's own steps. The bench keeps within this by issuing every operation through a task that raises a single strobe for one cycle and then waits for `busy` to fall. The one deliberate overlap is the priority test, which pairs a software write with a push in `ST_IDLE`.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CALL_MID,
        ST_CALL_LOW,
        ST_POP_WAIT,
        ST_RET_MID,
        ST_RET_HIGH,
        ST_RET_DONE
    } sp_state_e;

    localparam int RET_ADDR_W = 24;
    localparam int BYTE_W     = 8;

endpackage

// File: rtl/sp_ptr_reg.sv
module sp_ptr_reg #(
    parameter bit          HAS_HIGH = 1'b1,
    parameter logic [15:0] RST_VAL  = 16'h02FF,
    localparam int         PTR_W    = HAS_HIGH ? 16 : 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wdata,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_d
);

    logic [PTR_W-1:0] stepped;

    always_comb begin
        stepped = ptr_q;
        if (step_up)
            stepped = ptr_q + 1'b1;
        else if (step_dn)
            stepped = ptr_q - 1'b1;
    end

    generate
        if (HAS_HIGH) begin : g_wide
            always_comb begin
                ptr_d = stepped;
                if (wr_lo || wr_hi) begin
                    ptr_d = ptr_q;
                    if (wr_lo) ptr_d[7:0]  = wdata;
                    if (wr_hi) ptr_d[15:8] = wdata;
                end
            end
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = wr_hi;
            always_comb begin
                ptr_d = stepped;
                if (wr_lo) ptr_d = wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= RST_VAL[PTR_W-1:0];
        else
            ptr_q <= ptr_d;
    end

endmodule

// File: rtl/sp_floor_flag.sv
module sp_floor_flag #(
    parameter int          PTR_W = 16,
    parameter logic [15:0] FLOOR = 16'h0200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr,
    input  logic [PTR_W-1:0] ptr_d,
    output logic             err_q
);

    logic [15:0] next_wide;
    assign next_wide = 16'(ptr_d);

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (sw_wr)
            err_q <= (next_wide < FLOOR);
    end

endmodule

// File: rtl/sp_seq_fsm.sv
module sp_seq_fsm
    import sp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_push,
    input  logic        cmd_pop,
    input  logic        cmd_call,
    input  logic        cmd_ret,
    input  logic        sw_wr,
    input  logic [7:0]  push_data,
    input  logic [23:0] ret_addr_in,
    input  logic [7:0]  mem_rdata,
    output logic        step_up,
    output logic        step_dn,
    output logic        addr_plus1,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    output logic        busy,
    output logic        pop_valid,
    output logic [7:0]  pop_data,
    output logic        ret_valid,
    output logic [23:0] ret_addr_out
);

    sp_state_e   state_q, state_d;
    logic [15:0] call_tail_q;
    logic [7:0]  ret_low_q;
    logic [7:0]  ret_mid_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // byte holding registers for the multi-cycle sequences
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_tail_q <= '0;
            ret_low_q   <= '0;
            ret_mid_q   <= '0;
        end else begin
            if (state_q == ST_IDLE)     call_tail_q <= ret_addr_in[15:0];
            if (state_q == ST_RET_MID)  ret_low_q   <= mem_rdata;
            if (state_q == ST_RET_HIGH) ret_mid_q   <= mem_rdata;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        step_up    = 1'b0;
        step_dn    = 1'b0;
        addr_plus1 = 1'b0;
        mem_we     = 1'b0;
        mem_re     = 1'b0;
        mem_wdata  = push_data;
        busy       = 1'b1;
        pop_valid  = 1'b0;
        ret_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (!sw_wr) begin
                    if (cmd_push) begin
                        mem_we  = 1'b1;
                        step_dn = 1'b1;
                    end else if (cmd_pop) begin
                        mem_re     = 1'b1;
                        addr_plus1 = 1'b1;
                        step_up    = 1'b1;
                        state_d    = ST_POP_WAIT;
                    end else if (cmd_call) begin
                        mem_we    = 1'b1;
                        mem_wdata = ret_addr_in[23:16];
                        step_dn   = 1'b1;
                        state_d   = ST_CALL_MID;
                    end else if (cmd_ret) begin
                        mem_re     = 1'b1;
                        addr_plus1 = 1'b1;
                        step_up    = 1'b1;
                        state_d    = ST_RET_MID;
                    end
                end
            end
            ST_CALL_MID: begin
                mem_we    = 1'b1;
                mem_wdata = call_tail_q[15:8];
                step_dn   = 1'b1;
                state_d   = ST_CALL_LOW;
            end
            ST_CALL_LOW: begin
                mem_we    = 1'b1;
                mem_wdata = call_tail_q[7:0];
                step_dn   = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_POP_WAIT: begin
                pop_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_RET_MID: begin
                mem_re     = 1'b1;
                addr_plus1 = 1'b1;
                step_up    = 1'b1;
                state_d    = ST_RET_HIGH;
            end
            ST_RET_HIGH: begin
                mem_re     = 1'b1;
                addr_plus1 = 1'b1;
                step_up    = 1'b1;
                state_d    = ST_RET_DONE;
            end
            ST_RET_DONE: begin
                ret_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign pop_data     = mem_rdata;
    assign ret_addr_out = {mem_rdata, ret_mid_q, ret_low_q};

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
    parameter logic [15:0] SRAM_LAST = 16'h02FF,
    parameter logic [15:0] FLOOR     = 16'h0200,
    parameter bit          HAS_HIGH  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_wr_lo,
    input  logic        sw_wr_hi,
    input  logic [7:0]  sw_wdata,
    output logic [7:0]  rd_lo,
    output logic [7:0]  rd_hi,
    output logic        floor_err,
    input  logic        cmd_push,
    input  logic        cmd_pop,
    input  logic        cmd_call,
    input  logic        cmd_ret,
    input  logic [7:0]  push_data,
    input  logic [23:0] ret_addr_in,
    output logic        busy,
    output logic        pop_valid,
    output logic [7:0]  pop_data,
    output logic        ret_valid,
    output logic [23:0] ret_addr_out,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);

    localparam int PTR_W = HAS_HIGH ? 16 : 8;

    logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc;
    logic             step_up, step_dn, addr_plus1;
    logic             sw_wr;
    logic             sw_wr_hi_eff;

    assign sw_wr_hi_eff = HAS_HIGH ? sw_wr_hi : 1'b0;
    assign sw_wr        = sw_wr_lo | sw_wr_hi_eff;
    assign ptr_inc      = ptr_q + 1'b1;
    assign mem_addr     = addr_plus1 ? 16'(ptr_inc) : 16'(ptr_q);

    sp_ptr_reg #(
        .HAS_HIGH (HAS_HIGH),
        .RST_VAL  (SRAM_LAST)
    ) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (sw_wr_lo),
        .wr_hi   (sw_wr_hi_eff),
        .wdata   (sw_wdata),
        .step_up (step_up),
        .step_dn (step_dn),
        .ptr_q   (ptr_q),
        .ptr_d   (ptr_d)
    );

    sp_floor_flag #(
        .PTR_W (PTR_W),
        .FLOOR (FLOOR)
    ) u_floor (
        .clk   (clk),
        .rst_n (rst_n),
        .sw_wr (sw_wr),
        .ptr_d (ptr_d),
        .err_q (floor_err)
    );

    sp_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_push     (cmd_push),
        .cmd_pop      (cmd_pop),
        .cmd_call     (cmd_call),
        .cmd_ret      (cmd_ret),
        .sw_wr        (sw_wr),
        .push_data    (push_data),
        .ret_addr_in  (ret_addr_in),
        .mem_rdata    (mem_rdata),
        .step_up      (step_up),
        .step_dn      (step_dn),
        .addr_plus1   (addr_plus1),
        .mem_we       (mem_we),
        .mem_re       (mem_re),
        .mem_wdata    (mem_wdata),
        .busy         (busy),
        .pop_valid    (pop_valid),
        .pop_data     (pop_data),
        .ret_valid    (ret_valid),
        .ret_addr_out (ret_addr_out)
    );

    assign rd_lo = ptr_q[7:0];

    generate
        if (HAS_HIGH) begin : g_hi_rd
            assign rd_hi = ptr_q[PTR_W-1:8];
        end else begin : g_hi_none
            assign rd_hi = 8'h00;
        end
    endgenerate

endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
    parameter bit          HAS_HIGH = 1'b1,
    parameter logic [15:0] FLOOR    = 16'h0200
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_wr_lo,
    input logic        sw_wr_hi,
    input logic [7:0]  sw_wdata,
    input logic [7:0]  rd_lo,
    input logic [7:0]  rd_hi,
    input logic        floor_err,
    input logic        cmd_push,
    input logic        cmd_pop,
    input logic        cmd_call,
    input logic        cmd_ret,
    input logic [7:0]  push_data,
    input logic        busy,
    input logic        pop_valid,
    input logic        ret_valid,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic [7:0]  mem_wdata
);

    localparam logic [15:0] MASK = HAS_HIGH ? 16'hFFFF : 16'h00FF;

    logic [15:0] ptr;
    logic        sw_any, accept, cmd_any;

    assign ptr     = {rd_hi, rd_lo};
    assign sw_any  = sw_wr_lo | (sw_wr_hi & HAS_HIGH);
    assign accept  = !busy && !sw_any;
    assign cmd_any = cmd_push | cmd_pop | cmd_call | cmd_ret;

    a_r2_push_access: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_push |-> mem_we && mem_addr == ptr && mem_wdata == push_data);

    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_push |=> ptr == (($past(ptr) - 16'd1) & MASK));

    a_r3_call_net: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_call |=> ##2 ptr == (($past(ptr, 3) - 16'd3) & MASK));

    a_r3_call_busy: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_call |=> busy && mem_we);

    a_r4_pop_access: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_pop |-> mem_re && mem_addr == ((ptr + 16'd1) & MASK));

    a_r4_pop_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_pop |=> pop_valid);

    a_r5_ret_net: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_ret |=> ##2 ptr == (($past(ptr, 3) + 16'd3) & MASK));

    a_r5_ret_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_ret |=> ##2 ret_valid);

    a_r6_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_lo |=> rd_lo == $past(sw_wdata));

    a_r7_floor_eval: assert property (@(posedge clk) disable iff (!rst_n)
        sw_any |=> floor_err == (ptr < FLOOR));

    a_r7_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_any |=> $stable(floor_err));

    a_r8_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_HIGH |-> rd_hi == 8'h00);

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any && !busy && sw_any |-> !mem_we && !mem_re);

    a_r4_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(
    .HAS_HIGH (HAS_HIGH),
    .FLOOR    (FLOOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_wr_lo  (sw_wr_lo),
    .sw_wr_hi  (sw_wr_hi),
    .sw_wdata  (sw_wdata),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .floor_err (floor_err),
    .cmd_push  (cmd_push),
    .cmd_pop   (cmd_pop),
    .cmd_call  (cmd_call),
    .cmd_ret   (cmd_ret),
    .push_data (push_data),
    .busy      (busy),
    .pop_valid (pop_valid),
    .ret_valid (ret_valid),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata)
);

// File: tb/stack_ptr_unit_test.sv
module stack_ptr_unit_test;

    localparam logic [2:0] OP_PUSH = 3'd0;
    localparam logic [2:0] OP_POP  = 3'd1;
    localparam logic [2:0] OP_CALL = 3'd2;
    localparam logic [2:0] OP_RET  = 3'd3;
    localparam logic [2:0] OP_WRLO = 3'd4;
    localparam logic [2:0] OP_WRHI = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [23:0] arg;
        logic [15:0] exp_ptr;
        logic [23:0] exp_val;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{OP_PUSH, 24'h0000A5, 16'h02FE, 24'h0},
        '{OP_PUSH, 24'h00003C, 16'h02FD, 24'h0},
        '{OP_CALL, 24'h123456, 16'h02FA, 24'h0},
        '{OP_PUSH, 24'h000077, 16'h02F9, 24'h0},
        '{OP_POP,  24'h000000, 16'h02FA, 24'h000077},
        '{OP_RET,  24'h000000, 16'h02FD, 24'h123456},
        '{OP_POP,  24'h000000, 16'h02FE, 24'h00003C},
        '{OP_POP,  24'h000000, 16'h02FF, 24'h0000A5},
        '{OP_WRLO, 24'h000010, 16'h0210, 24'h0},
        '{OP_WRHI, 24'h000003, 16'h0310, 24'h0},
        '{OP_CALL, 24'hABCDEF, 16'h030D, 24'h0},
        '{OP_RET,  24'h000000, 16'h0310, 24'hABCDEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_lo = 1'b0, sw_wr_hi = 1'b0;
    logic [7:0]  sw_wdata = '0;
    logic        cmd_push = 1'b0, cmd_pop = 1'b0, cmd_call = 1'b0, cmd_ret = 1'b0;
    logic [7:0]  push_data = '0;
    logic [23:0] ret_addr_in = '0;
    logic [7:0]  rd_lo, rd_hi;
    logic        floor_err, busy, pop_valid, ret_valid, mem_we, mem_re;
    logic [7:0]  pop_data, mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [23:0] ret_addr_out;
    logic [15:0] mem_addr;

    logic        s_wr_lo = 1'b0, s_wr_hi = 1'b0, s_push = 1'b0;
    logic [7:0]  s_wdata = '0;
    logic [7:0]  s_rd_lo, s_rd_hi, s_pop_data, s_mem_wdata;
    logic        s_floor, s_busy, s_pop_valid, s_ret_valid, s_we, s_re;
    logic [23:0] s_ret_addr;
    logic [15:0] s_addr;

    logic [7:0]  mem [1024];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
    end

    stack_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .sw_wr_lo(sw_wr_lo), .sw_wr_hi(sw_wr_hi),
        .sw_wdata(sw_wdata), .rd_lo(rd_lo), .rd_hi(rd_hi), .floor_err(floor_err),
        .cmd_push(cmd_push), .cmd_pop(cmd_pop), .cmd_call(cmd_call), .cmd_ret(cmd_ret),
        .push_data(push_data), .ret_addr_in(ret_addr_in), .busy(busy),
        .pop_valid(pop_valid), .pop_data(pop_data), .ret_valid(ret_valid),
        .ret_addr_out(ret_addr_out), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    stack_ptr_unit #(
        .SRAM_LAST(16'h00DF), .FLOOR(16'h0060), .HAS_HIGH(1'b0)
    ) uut_small (
        .clk(clk), .rst_n(rst_n), .sw_wr_lo(s_wr_lo), .sw_wr_hi(s_wr_hi),
        .sw_wdata(s_wdata), .rd_lo(s_rd_lo), .rd_hi(s_rd_hi), .floor_err(s_floor),
        .cmd_push(s_push), .cmd_pop(1'b0), .cmd_call(1'b0), .cmd_ret(1'b0),
        .push_data(8'h5A), .ret_addr_in(24'h0), .busy(s_busy),
        .pop_valid(s_pop_valid), .pop_data(s_pop_data), .ret_valid(s_ret_valid),
        .ret_addr_out(s_ret_addr), .mem_addr(s_addr), .mem_we(s_we),
        .mem_re(s_re), .mem_wdata(s_mem_wdata), .mem_rdata(8'h00)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [23:0] arg, output logic [23:0] got);
        @(negedge clk);
        case (op)
            OP_PUSH: begin cmd_push = 1'b1; push_data = arg[7:0]; end
            OP_POP:  cmd_pop = 1'b1;
            OP_CALL: begin cmd_call = 1'b1; ret_addr_in = arg; end
            OP_RET:  cmd_ret = 1'b1;
            OP_WRLO: begin sw_wr_lo = 1'b1; sw_wdata = arg[7:0]; end
            default: begin sw_wr_hi = 1'b1; sw_wdata = arg[7:0]; end
        endcase
        @(negedge clk);
        cmd_push = 1'b0; cmd_pop = 1'b0; cmd_call = 1'b0; cmd_ret = 1'b0;
        sw_wr_lo = 1'b0; sw_wr_hi = 1'b0;
        got = '0;
        while (busy) begin
            if (pop_valid) got = {16'h0, pop_data};
            if (ret_valid) got = ret_addr_out;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ptr", {16'h0, rd_hi, rd_lo}, 32'h02FF);
        chk("R1 floor", {31'h0, floor_err}, 32'h0);
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 strobes", {30'h0, mem_we, mem_re}, 32'h0);

        // vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            do_op(VEC[i].op, VEC[i].arg, got);
            chk($sformatf("R2/R3/R4/R5/R6 vec%0d ptr", i), {16'h0, rd_hi, rd_lo},
                {16'h0, VEC[i].exp_ptr});
            if (VEC[i].op == OP_POP || VEC[i].op == OP_RET)
                chk($sformatf("R4/R5 vec%0d data", i), {8'h0, got}, {8'h0, VEC[i].exp_val});
            chk($sformatf("R7 vec%0d floor", i), {31'h0, floor_err}, 32'h0);
        end

        // R3 byte order of the first call in memory
        chk("R3 hi byte at P",   {24'h0, mem[10'h2FD]}, 32'h12);
        chk("R3 mid byte at P-1", {24'h0, mem[10'h2FC]}, 32'h34);
        chk("R3 low byte at P-2", {24'h0, mem[10'h2FB]}, 32'h56);
        chk("R2 first push at reset ptr", {24'h0, mem[10'h2FF]}, 32'hA5);

        // R2 push address on the port, same cycle
        @(negedge clk);
        cmd_push = 1'b1; push_data = 8'h99;
        #1;
        chk("R2 push addr", {16'h0, mem_addr}, 32'h0310);
        chk("R2 push we", {31'h0, mem_we}, 32'h1);
        @(negedge clk);
        cmd_push = 1'b0;
        chk("R2 push step", {16'h0, rd_hi, rd_lo}, 32'h030F);

        // R9 software write beats push in the same cycle
        @(negedge clk);
        cmd_push = 1'b1; push_data = 8'hEE; sw_wr_lo = 1'b1; sw_wdata = 8'h40;
        #1;
        chk("R9 no we", {31'h0, mem_we}, 32'h0);
        chk("R9 no re", {31'h0, mem_re}, 32'h0);
        @(negedge clk);
        cmd_push = 1'b0; sw_wr_lo = 1'b0;
        chk("R9 ptr takes write", {16'h0, rd_hi, rd_lo}, 32'h0340);
        chk("R9 memory untouched", {24'h0, mem[10'h30F]}, 32'hCD);

        // R7 floor flag
        do_op(OP_WRHI, 24'h01, got);
        chk("R7 below floor", {31'h0, floor_err}, 32'h1);
        do_op(OP_PUSH, 24'h11, got);
        chk("R7 push keeps flag", {31'h0, floor_err}, 32'h1);
        do_op(OP_WRHI, 24'h02, got);
        do_op(OP_WRLO, 24'h00, got);
        chk("R7 at floor clear", {31'h0, floor_err}, 32'h0);
        do_op(OP_PUSH, 24'h22, got);
        chk("R7 push under floor ptr", {16'h0, rd_hi, rd_lo}, 32'h01FF);
        chk("R7 push under floor flag", {31'h0, floor_err}, 32'h0);
        do_op(OP_WRLO, 24'hFF, got);
        chk("R7 write under floor", {31'h0, floor_err}, 32'h1);

        // R8 narrow configuration
        chk("R8 reset lo", {24'h0, s_rd_lo}, 32'hDF);
        chk("R8 reset hi", {24'h0, s_rd_hi}, 32'h0);
        @(negedge clk);
        s_wr_hi = 1'b1; s_wdata = 8'h05;
        @(negedge clk);
        s_wr_hi = 1'b0;
        chk("R8 hi write ignored", {16'h0, s_rd_hi, s_rd_lo}, 32'h00DF);
        s_wr_lo = 1'b1; s_wdata = 8'h00;
        @(negedge clk);
        s_wr_lo = 1'b0;
        chk("R8 narrow floor", {31'h0, s_floor}, 32'h1);
        s_push = 1'b1;
        @(negedge clk);
        s_push = 1'b0;
        chk("R8 wrap within byte", {16'h0, s_rd_hi, s_rd_lo}, 32'h00FF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule